// File: doc/BRIEF.md
# Display Refresh Completion Poller

Once a host has pushed a full frame into an electrophoretic display controller, the panel spends between one and several seconds physically redrawing. This block takes over after the frame has gone out. It repeatedly asks the controller whether the redraw has ended and reports the answer as a single flag. A check selects the controller, issues eight serial clocks and captures the byte the controller returns on its serial output. A byte of all zeros means the redraw is finished. All ones means it is still running. Any other value is recorded as a protocol error and treated as still running.

The controller drives a busy line and discards all serial traffic while that line is high. The poller therefore keeps chip select deasserted and the serial clock idle for as long as busy is high. If busy rises in the middle of a check, that check is abandoned. Checks are separated by a programmable quiet interval. A programmable limit, counted from the start strobe, stops the polling and raises a sticky timeout flag.

The states are IDLE, WAIT (select high, waiting for busy low), SETTLE (select low for one half clock period), SHIFT (eight clocks), EVAL (judge the byte), GAP (quiet interval), DONE and TOUT. The transitions are:
- start → WAIT from any state.
- WAIT → SETTLE when busy is low, or WAIT → TOUT when the limit has elapsed.
- SETTLE → SHIFT.
- SETTLE or SHIFT → WAIT when busy rises.
- SHIFT → EVAL after the eighth clock.
- EVAL → DONE on a zero byte, otherwise EVAL → TOUT when the limit has elapsed, otherwise EVAL → GAP.
- GAP → WAIT after the interval, or GAP → TOUT when the limit has elapsed.

Top module: `epd_update_poller`

## Requirements
- R1: After reset, chip select is high (deselected), the serial clock is low, and the done, timeout and error flags are low.
- R2: A start pulse clears all three flags and begins polling. While busy is high, chip select stays high and no serial clock edge is issued.
- R3: Each check drives chip select low and issues exactly eight rising serial clock edges. The clock is low whenever chip select is high. Bits are captured on the rising edge, most significant bit first.
- R4: A returned byte of 0x00 sets done. Done stays set, with no further checks, until the next start.
- R5: A returned byte of 0xFF starts a new check after a quiet interval of GAP_CYC cycles with chip select high.
- R6: A returned byte other than 0x00 or 0xFF sets a sticky error flag and is handled like 0xFF.
- R7: If busy rises during a check, the serial clock is low and chip select is high from the next cycle on. A fresh check follows once busy falls.
- R8: When TMO_CYC cycles have passed since start without a 0x00 result, polling stops and timeout stays set until the next start. This also applies when busy never falls.
- R9: A check already under way when the limit elapses runs to completion. If it returns 0x00, done is set and timeout is not.
- R10: Done and timeout are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe that starts polling after a frame |
| busy_i | input | 1 | Controller busy; serial input is ignored while high |
| sdo_i | input | 1 | Serial data returned by the controller |
| sclk_o | output | 1 | Serial clock to the controller, idle low |
| cs_n_o | output | 1 | Chip select, active low |
| done_o | output | 1 | Redraw finished (sticky until start) |
| timeout_o | output | 1 | Limit reached without completion (sticky until start) |
| err_o | output | 1 | An unexpected status byte was seen (sticky until start) |

## Verification
Two events can fall in the same cycle: the end of the timeout limit and the evaluation of a status byte, or the limit and the middle of a shift. The bench holds busy until a check that straddles the limit is under way. It then lets the controller model answer 0x00 in one run and 0xFF in another. The first run must end with done and no timeout after one check; the second must end with timeout after that same single check. A second overlap, busy rising during the shift, is provoked after the third clock edge. It is judged by the absence of clock edges while busy is high and by the check being reissued afterwards.

// File: rtl/epd_poll_pkg.sv
package epd_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETTLE,
        ST_SHIFT,
        ST_EVAL,
        ST_GAP,
        ST_DONE,
        ST_TOUT
    } poll_state_t;

    localparam logic [7:0] STATUS_READY = 8'h00;
    localparam logic [7:0] STATUS_BUSY  = 8'hFF;

    function automatic logic is_running(poll_state_t s);
        return (s != ST_IDLE) && (s != ST_DONE) && (s != ST_TOUT);
    endfunction

endpackage

// File: rtl/poll_count.sv
module poll_count #(
    parameter int MAX = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          en,
    output logic [$clog2(MAX + 1) - 1:0]  cnt
);
    localparam int W = $clog2(MAX + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != W'(MAX))) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/poll_shifter.sv
module poll_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sdo_i,
    output logic       sclk_o,
    output logic [7:0] rx_o,
    output logic       fin_o
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [HW-1:0] half_q;
    logic [2:0]    bit_q;
    logic          sclk_q;
    logic [7:0]    rx_q;
    logic          half_end;

    assign half_end = (half_q == HW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            rx_q   <= '0;
        end else if (!run) begin
            half_q <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
        end else if (half_end) begin
            half_q <= '0;
            sclk_q <= !sclk_q;
            if (!sclk_q) begin
                rx_q <= {rx_q[6:0], sdo_i};
            end else begin
                bit_q <= bit_q + 3'd1;
            end
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign rx_o   = rx_q;
    assign fin_o  = half_end && sclk_q && (bit_q == 3'd7);
endmodule

// File: rtl/epd_update_poller.sv
module epd_update_poller
    import epd_poll_pkg::*;
#(
    parameter int HALF_CYC = 1000,
    parameter int GAP_CYC  = 12_500_000,
    parameter int TMO_CYC  = 637_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    input  logic sdo_i,
    output logic sclk_o,
    output logic cs_n_o,
    output logic done_o,
    output logic timeout_o,
    output logic err_o
);
    localparam int DLY_MAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
    localparam int DW      = $clog2(DLY_MAX + 1);
    localparam int TW      = $clog2(TMO_CYC + 1);

    poll_state_t state_q, state_d;

    logic [DW-1:0] dly_cnt;
    logic [TW-1:0] tmo_cnt;
    logic [7:0]    rx_byte;
    logic          shift_fin;
    logic          tmo_hit;
    logic          gap_end;
    logic          settle_end;
    logic          dly_clr;
    logic          shift_run;

    assign dly_clr    = !((state_q == ST_GAP) || (state_q == ST_SETTLE));
    assign gap_end    = (dly_cnt == DW'(GAP_CYC - 1));
    assign settle_end = (dly_cnt == DW'(HALF_CYC - 1));
    assign tmo_hit    = (tmo_cnt == TW'(TMO_CYC));
    assign shift_run  = (state_d == ST_SHIFT);

    poll_count #(.MAX(DLY_MAX)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dly_clr),
        .en    (1'b1),
        .cnt   (dly_cnt)
    );

    poll_count #(.MAX(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_i),
        .en    (is_running(state_q)),
        .cnt   (tmo_cnt)
    );

    poll_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (shift_run),
        .sdo_i  (sdo_i),
        .sclk_o (sclk_o),
        .rx_o   (rx_byte),
        .fin_o  (shift_fin)
    );

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WAIT: begin
                    if (tmo_hit)      state_d = ST_TOUT;
                    else if (!busy_i) state_d = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (busy_i)          state_d = ST_WAIT;
                    else if (settle_end) state_d = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (busy_i)         state_d = ST_WAIT;
                    else if (shift_fin) state_d = ST_EVAL;
                end
                ST_EVAL: begin
                    if (rx_byte == STATUS_READY) state_d = ST_DONE;
                    else if (tmo_hit)            state_d = ST_TOUT;
                    else                         state_d = ST_GAP;
                end
                ST_GAP: begin
                    if (tmo_hit)      state_d = ST_TOUT;
                    else if (gap_end) state_d = ST_WAIT;
                end
                ST_DONE:   state_d = ST_DONE;
                ST_TOUT:   state_d = ST_TOUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o    <= 1'b1;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            cs_n_o    <= !((state_d == ST_SETTLE) || (state_d == ST_SHIFT));
            done_o    <= (state_d == ST_DONE);
            timeout_o <= (state_d == ST_TOUT);
            if (start_i) begin
                err_o <= 1'b0;
            end else if ((state_q == ST_EVAL) && (rx_byte != STATUS_READY)
                         && (rx_byte != STATUS_BUSY)) begin
                err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/epd_update_poller_chk.sv
module epd_update_poller_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_i,
    input logic sclk_o,
    input logic cs_n_o,
    input logic done_o,
    input logic timeout_o,
    input logic err_o
);
    // R2: busy keeps the device deselected
    a_r2_busy_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> cs_n_o);

    // R3: clock toggles only while selected
    a_r3_clk_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    // R7: no clock following a busy sample
    a_r7_busy_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !sclk_o);

    // R4: done holds until a new start
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R4: no traffic after completion
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o);

    // R8: timeout holds and the bus is quiet
    a_r8_tout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !start_i) |=> (timeout_o && cs_n_o && !sclk_o));

    // R6: error flag only clears on start
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    // R10: outcomes exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));
endmodule

bind epd_update_poller epd_update_poller_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_i    (busy_i),
    .sclk_o    (sclk_o),
    .cs_n_o    (cs_n_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .err_o     (err_o)
);

// File: tb/epd_update_poller_tb_top.sv
module epd_update_poller_tb_top;

    localparam int HALF = 2;
    localparam int GAP  = 10;
    localparam int TMO  = 400;
    localparam int NV   = 9;

    // busy cycles, three replies, expected done/timeout/err, expected checks (-1 = any)
    localparam int VB [NV] = '{0, 20, 0, 60, 0, 0, 1000, 380, 380};
    localparam int V0 [NV] = '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h80, 8'hFF, 8'h00, 8'h00, 8'hFF};
    localparam int V1 [NV] = '{8'h00, 8'hFF, 8'h5A, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h00, 8'hFF};
    localparam int V2 [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF};
    localparam int VD [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 0};
    localparam int VT [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1};
    localparam int VE [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0};
    localparam int VP [NV] = '{1, 3, 3, 1, 3, -1, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_i = 1'b0;
    logic sdo_i = 1'b0;
    logic sclk_o, cs_n_o, done_o, timeout_o, err_o;

    int n_run = 0;
    int n_fail = 0;
    int pcnt = 0;
    int rises = 0;
    int busy_rises = 0;
    bit clk8_chk = 1'b1;
    logic [7:0] resp [3];
    logic [7:0] sh = 8'h00;

    always #4 clk = ~clk;

    epd_update_poller #(.HALF_CYC(HALF), .GAP_CYC(GAP), .TMO_CYC(TMO)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .busy_i    (busy_i),
        .sdo_i     (sdo_i),
        .sclk_o    (sclk_o),
        .cs_n_o    (cs_n_o),
        .done_o    (done_o),
        .timeout_o (timeout_o),
        .err_o     (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // controller model: loads a reply on select, shifts on falling clock
    always @(negedge cs_n_o) begin
        sh = resp[(pcnt > 2) ? 2 : pcnt];
        pcnt++;
        rises = 0;
        sdo_i = sh[7];
    end

    always @(negedge sclk_o) begin
        if (cs_n_o == 1'b0) begin
            sh = {sh[6:0], 1'b0};
            sdo_i = sh[7];
        end
    end

    always @(posedge sclk_o) begin
        rises++;
        if (busy_i) busy_rises++;
    end

    // R3: eight clock edges per check
    always @(posedge cs_n_o) begin
        if (rst_n && clk8_chk) chk(rises == 8, "R3 clocks per check", rises, 8);
    end

    task automatic wait_end();
        for (int i = 0; i < 3000 && !(done_o || timeout_o); i++) @(negedge clk);
    endtask

    task automatic run_vec(input int bcyc, input int b0, input int b1, input int b2);
        resp[0] = b0[7:0];
        resp[1] = b1[7:0];
        resp[2] = b2[7:0];
        pcnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        busy_i  = (bcyc > 0);
        @(negedge clk);
        start_i = 1'b0;
        repeat (bcyc) @(negedge clk);
        busy_i = 1'b0;
        wait_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p0;
        int bad;
        resp[0] = 8'h00;
        resp[1] = 8'h00;
        resp[2] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
        chk({done_o, timeout_o, err_o} == 3'b000, "R1 flags", {done_o, timeout_o, err_o}, 0);

        // table: R4 R5 R6 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            run_vec(VB[v], V0[v], V1[v], V2[v]);
            repeat (3) @(negedge clk);
            chk(done_o == VD[v][0], "R4/R9 done", done_o, VD[v]);
            chk(timeout_o == VT[v][0], "R8/R9 timeout", timeout_o, VT[v]);
            chk(err_o == VE[v][0], "R6 err", err_o, VE[v]);
            if (VP[v] >= 0) chk(pcnt == VP[v], "R5 checks issued", pcnt, VP[v]);
            p0 = pcnt;
            repeat (80) @(negedge clk);
            chk(pcnt == p0, "R4/R8 quiet after end", pcnt, p0);
            chk(!(done_o && timeout_o), "R10 exclusive", 1, 0);
        end

        // R7: busy rises mid-shift
        resp[0] = 8'hFF;
        resp[1] = 8'h00;
        resp[2] = 8'h00;
        pcnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 2000 && rises < 3; i++) @(negedge clk);
        clk8_chk = 1'b0;
        busy_rises = 0;
        busy_i = 1'b1;
        bad = 0;
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!cs_n_o || sclk_o) bad++;
        end
        chk(bad == 0, "R7 quiet while busy", bad, 0);
        chk(busy_rises == 0, "R7 clocks during busy", busy_rises, 0);
        clk8_chk = 1'b1;
        busy_i = 1'b0;
        wait_end();
        repeat (2) @(negedge clk);
        chk(done_o == 1'b1, "R7 check reissued and done", done_o, 1);
        chk(pcnt == 2, "R7 checks after abort", pcnt, 2);

        // R2: restart clears flags and busy blocks traffic
        run_vec(0, 8'h5A, 8'h00, 8'h00);
        repeat (2) @(negedge clk);
        chk(err_o == 1'b1, "R6 err before restart", err_o, 1);
        pcnt = 0;
        resp[0] = 8'h00;
        start_i = 1'b1;
        busy_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk({done_o, timeout_o, err_o} == 3'b000, "R2 flags cleared", {done_o, timeout_o, err_o}, 0);
        bad = 0;
        busy_rises = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cs_n_o) bad++;
        end
        chk(bad == 0 && pcnt == 0, "R2 no select while busy", pcnt + bad, 0);
        chk(busy_rises == 0, "R2 no clock while busy", busy_rises, 0);
        busy_i = 1'b0;
        wait_end();
        repeat (2) @(negedge clk);
        chk(done_o == 1'b1 && pcnt == 1, "R2 poll after busy", pcnt, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule